// File: doc/BRIEF.md
# Complex Block Exponent Box Codec

This block converts complex samples between two block floating-point layouts. The first layout holds one shared exponent per block, and every component is right-aligned against that exponent. The second layout adds one flag bit per real component and one per imaginary component. When a component sits far below the shared exponent, its flag is set and its mantissa is aligned to a reference that is BOX_K positions lower. This keeps leading bits that plain alignment would shift away. Each complex sample costs two extra bits. In exchange, the set of exponent pairs that can be stored without losing a mantissa becomes four times larger.

The block has two independent streaming paths, and each path has one register stage with a valid/ready handshake. The encode path takes the shared exponent and, for each component, a sign, an exponent and a full mantissa with its lead bit explicit. It emits the flagged, aligned form. The decode path takes the flagged form and returns two results at once for each component. The first is an effective exponent, used by multiply-style arithmetic. The second is a mantissa aligned to the shared exponent, used by add-style arithmetic. Component index 0 is the real part and index 1 is the imaginary part on every packed port.

Top module: `box_exp_codec`

## Requirements
- R1: After reset, both output valids are low and both input readies are high.
- R2: For each component, the deficit d is the shared exponent minus the component exponent, taken as 0 when the component exponent is larger. When d < BOX_K, the encoder clears the flag and stores the mantissa shifted right by d. This is the same result as plain shared-exponent alignment.
- R3: When d >= BOX_K, the encoder sets the flag and stores the mantissa shifted right by d - BOX_K. A shift of MANT_W or more stores zero.
- R4: The encoder passes the shared exponent and both sign bits to its output unchanged.
- R5: The decoder's effective exponent per component is the shared exponent minus BOX_K when the flag is set, and the shared exponent when it is clear. It is given as an (EXP_W+1)-bit two's-complement value.
- R6: The decoder's aligned mantissa equals the stored mantissa when the flag is clear. When the flag is set, it equals the stored mantissa shifted right by BOX_K, which is zero at the default BOX_K = MANT_W. Signs pass through unchanged.
- R7: On each path, a transfer takes place when in-valid and in-ready are both high at a clock edge. The result appears with out-valid on the next cycle. While out-valid is high and out-ready is low, the output holds its value.
- R8: The encode and decode paths are independent. Both can accept and deliver in the same cycle without affecting each other's results.
- R9: Take a component whose lead bit is set and whose deficit is below BOX_K + MANT_W. Its encoded mantissa is nonzero. Rebuilding it from the decoder's effective exponent never has more error than plain shared-exponent alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encInValid | input | 1 | Encode input valid |
| encInReady | output | 1 | Encode input ready |
| encCommonExp | input | EXP_W | Shared block exponent |
| encSign | input | 2 | Component signs |
| encExp | input | 2×EXP_W | Component exponents |
| encMant | input | 2×MANT_W | Component mantissas, lead bit at the MSB |
| encOutValid | output | 1 | Encode output valid |
| encOutReady | input | 1 | Encode output ready |
| encOutCommonExp | output | EXP_W | Shared exponent, passed through |
| encOutSign | output | 2 | Signs, passed through |
| encOutBox | output | 2 | Box flags |
| encOutMant | output | 2×MANT_W | Stored mantissas |
| decInValid | input | 1 | Decode input valid |
| decInReady | output | 1 | Decode input ready |
| decCommonExp | input | EXP_W | Shared block exponent |
| decSign | input | 2 | Component signs |
| decBox | input | 2 | Box flags |
| decMant | input | 2×MANT_W | Stored mantissas |
| decOutValid | output | 1 | Decode output valid |
| decOutReady | input | 1 | Decode output ready |
| decOutSign | output | 2 | Signs, passed through |
| decOutExp | output | 2×(EXP_W+1) | Effective exponents, two's complement |
| decOutAligned | output | 2×MANT_W | Mantissas aligned to the shared exponent |

## Verification
The encode and decode paths can both complete a transfer on the same clock edge. The bench provokes this by running two independent random streams with separate random back-pressure on each output. It counts the cycles in which both paths hand over data, and requires that count to be nonzero. Every word on each path is then compared against a queue of expected values that the bench computed when that word was accepted. If the two paths interfered with each other, a word on one side would not match its queue entry. In a final phase, each encoded sample is fed back into the decoder, so that the rebuilt error can be compared with plain shared-exponent alignment.

// File: rtl/boxcodec_pkg.sv
package boxcodec_pkg;
  localparam int NUM_COMP = 2;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;
endpackage

// File: rtl/boxcodec_ctrl.sv
module boxcodec_ctrl
  import boxcodec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    encInValid,
  output logic    encInReady,
  output logic    encOutValid,
  input  logic    encOutReady,
  input  logic    decInValid,
  output logic    decInReady,
  output logic    decOutValid,
  input  logic    decOutReady,
  output strobe_t strobe
);
  logic encFull, decFull;

  assign encInReady     = !encFull || encOutReady;
  assign decInReady     = !decFull || decOutReady;
  assign strobe.encLoad = encInValid && encInReady;
  assign strobe.decLoad = decInValid && decInReady;
  assign encOutValid    = encFull;
  assign decOutValid    = decFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encFull <= 1'b0;
      decFull <= 1'b0;
    end else begin
      if (strobe.encLoad)   encFull <= 1'b1;
      else if (encOutReady) encFull <= 1'b0;
      if (strobe.decLoad)   decFull <= 1'b1;
      else if (decOutReady) decFull <= 1'b0;
    end
  end
endmodule

// File: rtl/boxcodec_dp.sv
module boxcodec_dp
  import boxcodec_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 16,
  parameter int BOX_K  = MANT_W
) (
  input  logic                                clk,
  input  strobe_t                             strobe,
  input  logic [EXP_W-1:0]                    encCommonExp,
  input  logic [NUM_COMP-1:0]                 encSign,
  input  logic [NUM_COMP-1:0][EXP_W-1:0]      encExp,
  input  logic [NUM_COMP-1:0][MANT_W-1:0]     encMant,
  output logic [EXP_W-1:0]                    encOutCommonExp,
  output logic [NUM_COMP-1:0]                 encOutSign,
  output logic [NUM_COMP-1:0]                 encOutBox,
  output logic [NUM_COMP-1:0][MANT_W-1:0]     encOutMant,
  input  logic [EXP_W-1:0]                    decCommonExp,
  input  logic [NUM_COMP-1:0]                 decSign,
  input  logic [NUM_COMP-1:0]                 decBox,
  input  logic [NUM_COMP-1:0][MANT_W-1:0]     decMant,
  output logic [NUM_COMP-1:0]                 decOutSign,
  output logic [NUM_COMP-1:0][EXP_W:0]        decOutExp,
  output logic [NUM_COMP-1:0][MANT_W-1:0]     decOutAligned
);
  localparam logic [EXP_W-1:0] KE = BOX_K[EXP_W-1:0];
  localparam logic [EXP_W:0]   KX = {1'b0, KE};

  logic [NUM_COMP-1:0]             boxNext;
  logic [NUM_COMP-1:0][MANT_W-1:0] mantNext;
  logic [NUM_COMP-1:0][EXP_W:0]    expNext;
  logic [NUM_COMP-1:0][MANT_W-1:0] alignNext;

  for (genvar c = 0; c < NUM_COMP; c++) begin : gComp
    logic [EXP_W-1:0] deficit, shiftAmt;
    logic             far;

    always_comb begin
      deficit  = (encExp[c] > encCommonExp) ? '0 : encCommonExp - encExp[c];
      far      = deficit >= KE;
      shiftAmt = far ? deficit - KE : deficit;
      boxNext[c]  = far;
      mantNext[c] = encMant[c] >> shiftAmt;
    end

    always_comb begin
      expNext[c]   = {1'b0, decCommonExp} - (decBox[c] ? KX : '0);
      alignNext[c] = decBox[c] ? (decMant[c] >> KE) : decMant[c];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.encLoad) begin
      encOutCommonExp <= encCommonExp;
      encOutSign      <= encSign;
      encOutBox       <= boxNext;
      encOutMant      <= mantNext;
    end
    if (strobe.decLoad) begin
      decOutSign    <= decSign;
      decOutExp     <= expNext;
      decOutAligned <= alignNext;
    end
  end
endmodule

// File: rtl/box_exp_codec.sv
module box_exp_codec
  import boxcodec_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 16,
  parameter int BOX_K  = MANT_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            encInValid,
  output logic                            encInReady,
  input  logic [EXP_W-1:0]                encCommonExp,
  input  logic [1:0]                      encSign,
  input  logic [1:0][EXP_W-1:0]           encExp,
  input  logic [1:0][MANT_W-1:0]          encMant,
  output logic                            encOutValid,
  input  logic                            encOutReady,
  output logic [EXP_W-1:0]                encOutCommonExp,
  output logic [1:0]                      encOutSign,
  output logic [1:0]                      encOutBox,
  output logic [1:0][MANT_W-1:0]          encOutMant,
  input  logic                            decInValid,
  output logic                            decInReady,
  input  logic [EXP_W-1:0]                decCommonExp,
  input  logic [1:0]                      decSign,
  input  logic [1:0]                      decBox,
  input  logic [1:0][MANT_W-1:0]          decMant,
  output logic                            decOutValid,
  input  logic                            decOutReady,
  output logic [1:0]                      decOutSign,
  output logic [1:0][EXP_W:0]             decOutExp,
  output logic [1:0][MANT_W-1:0]          decOutAligned
);
  strobe_t strobe;

  boxcodec_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .encInValid(encInValid), .encInReady(encInReady),
    .encOutValid(encOutValid), .encOutReady(encOutReady),
    .decInValid(decInValid), .decInReady(decInReady),
    .decOutValid(decOutValid), .decOutReady(decOutReady),
    .strobe(strobe)
  );

  boxcodec_dp #(.EXP_W(EXP_W), .MANT_W(MANT_W), .BOX_K(BOX_K)) uDp (
    .clk(clk), .strobe(strobe),
    .encCommonExp(encCommonExp), .encSign(encSign), .encExp(encExp), .encMant(encMant),
    .encOutCommonExp(encOutCommonExp), .encOutSign(encOutSign),
    .encOutBox(encOutBox), .encOutMant(encOutMant),
    .decCommonExp(decCommonExp), .decSign(decSign), .decBox(decBox), .decMant(decMant),
    .decOutSign(decOutSign), .decOutExp(decOutExp), .decOutAligned(decOutAligned)
  );
endmodule

// File: rtl/box_exp_codec_chk.sv
module box_exp_codec_chk #(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 16,
  parameter int BOX_K  = MANT_W
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   encInValid,
  input logic                   encInReady,
  input logic [EXP_W-1:0]       encCommonExp,
  input logic [1:0][EXP_W-1:0]  encExp,
  input logic [1:0][MANT_W-1:0] encMant,
  input logic                   encOutValid,
  input logic                   encOutReady,
  input logic [1:0]             encOutBox,
  input logic [1:0][MANT_W-1:0] encOutMant,
  input logic                   decInValid,
  input logic                   decInReady,
  input logic [EXP_W-1:0]       decCommonExp,
  input logic [1:0]             decBox,
  input logic                   decOutValid,
  input logic                   decOutReady,
  input logic [1:0][EXP_W:0]    decOutExp
);
  localparam logic [EXP_W:0] KX   = BOX_K[EXP_W:0];
  localparam logic [EXP_W:0] KEEP = (BOX_K + MANT_W) > ((1 << (EXP_W + 1)) - 1)
                                    ? {(EXP_W+1){1'b1}} : (BOX_K + MANT_W);

  logic encAcc, decAcc;
  logic [EXP_W:0] def0;
  assign encAcc = encInValid && encInReady;
  assign decAcc = decInValid && decInReady;
  assign def0   = (encExp[0] > encCommonExp) ? '0 : {1'b0, encCommonExp} - {1'b0, encExp[0]};

  // R2
  near_box_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    encAcc && def0 < KX |=> !encOutBox[0]);
  // R3
  far_box_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    encAcc && def0 >= KX |=> encOutBox[0]);
  // R9
  lead_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    encAcc && encMant[0][MANT_W-1] && def0 < KEEP |=> encOutMant[0] != '0);
  // R7
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid && !encOutReady |=> encOutValid && $stable(encOutMant) && $stable(encOutBox));
  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> decOutValid && $stable(decOutExp));
  // R7
  enc_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    encAcc |=> encOutValid);
  // R5
  dec_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    decAcc |=> decOutExp[1] == ($past({1'b0, decCommonExp}) - ($past(decBox[1]) ? KX : '0)));
endmodule

bind box_exp_codec box_exp_codec_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W), .BOX_K(BOX_K)) uChk (
  .clk(clk), .rstN(rstN),
  .encInValid(encInValid), .encInReady(encInReady), .encCommonExp(encCommonExp),
  .encExp(encExp), .encMant(encMant),
  .encOutValid(encOutValid), .encOutReady(encOutReady),
  .encOutBox(encOutBox), .encOutMant(encOutMant),
  .decInValid(decInValid), .decInReady(decInReady), .decCommonExp(decCommonExp),
  .decBox(decBox), .decOutValid(decOutValid), .decOutReady(decOutReady),
  .decOutExp(decOutExp)
);

// File: tb/box_exp_codec_test.sv
module box_exp_codec_test;
  localparam int EW = 8;
  localparam int MW = 16;
  localparam int K  = MW;
  localparam int N_ENC = 300;
  localparam int N_DEC = 300;
  localparam int EOW = EW + 4 + 2*MW;
  localparam int DOW = 2 + 2*(EW+1) + 2*MW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic encInValid = 1'b0, encInReady, encOutValid, encOutReady = 1'b0;
  logic [EW-1:0] encCommonExp = '0, encOutCommonExp;
  logic [1:0] encSign = '0, encOutSign, encOutBox;
  logic [1:0][EW-1:0] encExp = '0;
  logic [1:0][MW-1:0] encMant = '0, encOutMant;
  logic decInValid = 1'b0, decInReady, decOutValid, decOutReady = 1'b0;
  logic [EW-1:0] decCommonExp = '0;
  logic [1:0] decSign = '0, decBox = '0, decOutSign;
  logic [1:0][MW-1:0] decMant = '0, decOutAligned;
  logic [1:0][EW:0] decOutExp;

  box_exp_codec #(.EXP_W(EW), .MANT_W(MW), .BOX_K(K)) uut (.*);

  int checks = 0, fails = 0, bothFire = 0;
  bit streaming = 1'b0, encDone = 1'b0, decDone = 1'b0, finished = 1'b0;
  logic [EOW-1:0] encQ[$];
  logic [DOW-1:0] decQ[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MW:0] encComp(input int ce, input int e, input logic [MW-1:0] m);
    int d, sh;
    logic box;
    d = (e > ce) ? 0 : ce - e;
    box = d >= K;
    sh = box ? d - K : d;
    return {box, (sh >= MW) ? {MW{1'b0}} : m >> sh};
  endfunction

  function automatic logic [EW:0] decExpF(input int ce, input logic box);
    return (EW+1)'(ce - (box ? K : 0));
  endfunction

  function automatic logic [MW-1:0] decAlignF(input logic [MW-1:0] m, input logic box);
    return box ? ((K >= MW) ? {MW{1'b0}} : m >> K) : m;
  endfunction

  function automatic int pickDeficit(input int i);
    int dir[8] = '{0, K-1, K, K+1, K+MW-1, K+MW, K+MW+3, 1};
    return (i < 8) ? dir[i] : int'($urandom % (K+MW+6));
  endfunction

  task automatic makeSample(input int i, output int ce, output int e0, output int e1);
    ce = 40 + int'($urandom % 200);
    e0 = ce - pickDeficit(i);
    e1 = ce - int'($urandom % (K+MW+6));
    if (i % 17 == 5) e1 = ce + 1;
    if (e0 < 0) e0 = 0;
    if (e1 < 0) e1 = 0;
  endtask

  // output back-pressure
  always @(negedge clk) if (streaming) begin
    encOutReady <= ($urandom % 3) != 0;
    decOutReady <= ($urandom % 4) != 0;
  end

  // monitors
  always @(negedge clk) begin
    #1;
    if (streaming) begin
      if (encOutValid && encOutReady && decOutValid && decOutReady) bothFire++;
      if (encOutValid && encOutReady && encQ.size() > 0) begin
        logic [EOW-1:0] exp, act;
        exp = encQ.pop_front();
        act = {encOutCommonExp, encOutSign, encOutBox, encOutMant};
        check(act == exp, "R2/R3/R4 encode word", 64'(act), 64'(exp));
      end
      if (decOutValid && decOutReady && decQ.size() > 0) begin
        logic [DOW-1:0] exp, act;
        exp = decQ.pop_front();
        act = {decOutSign, decOutExp, decOutAligned};
        check(act == exp, "R5/R6 decode word", 64'(act), 64'(exp));
      end
    end
  end

  // encode driver
  initial begin
    wait (streaming);
    for (int i = 0; i < N_ENC; i++) begin
      int ce, e0, e1;
      logic [MW:0] r0, r1;
      logic [1:0][MW-1:0] m;
      @(negedge clk);
      makeSample(i, ce, e0, e1);
      m[0] = {1'b1, MW'($urandom)} ; m[1] = {1'b1, MW'($urandom)};
      m[0][MW-1] = 1'b1; m[1][MW-1] = 1'b1;
      encCommonExp = EW'(ce); encExp[0] = EW'(e0); encExp[1] = EW'(e1);
      encMant = m; encSign = 2'($urandom); encInValid = 1'b1;
      #1;
      while (!encInReady) begin @(negedge clk); #1; end
      r0 = encComp(ce, e0, m[0]); r1 = encComp(ce, e1, m[1]);
      encQ.push_back({EW'(ce), encSign, r1[MW], r0[MW], r1[MW-1:0], r0[MW-1:0]});
    end
    @(negedge clk) encInValid = 1'b0;
    encDone = 1'b1;
  end

  // decode driver
  initial begin
    wait (streaming);
    for (int i = 0; i < N_DEC; i++) begin
      int ce;
      @(negedge clk);
      ce = (i < 4) ? i * 5 : int'($urandom % (1 << EW));
      decCommonExp = EW'(ce); decBox = 2'($urandom); decSign = 2'($urandom);
      decMant[0] = MW'($urandom); decMant[1] = MW'($urandom); decInValid = 1'b1;
      #1;
      while (!decInReady) begin @(negedge clk); #1; end
      decQ.push_back({decSign, decExpF(ce, decBox[1]), decExpF(ce, decBox[0]),
                      decAlignF(decMant[1], decBox[1]), decAlignF(decMant[0], decBox[0])});
    end
    @(negedge clk) decInValid = 1'b0;
    decDone = 1'b1;
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hang expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1
    check(!encOutValid && !decOutValid, "R1 valids low in reset", {encOutValid, decOutValid}, 0);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1
    check(encInReady && decInReady, "R1 readies high", {encInReady, decInReady}, 2'b11);
    streaming = 1'b1;
    wait (encDone && decDone);
    encOutReady = 1'b1; decOutReady = 1'b1;
    repeat (4) @(negedge clk);
    streaming = 1'b0;
    // R8
    check(bothFire > 0, "R8 simultaneous transfers", bothFire, 1);
    check(encQ.size() == 0 && decQ.size() == 0, "R7/R8 all words delivered",
          encQ.size() + decQ.size(), 0);
    // R9 round trip through encoder then decoder
    for (int i = 0; i < 60; i++) begin
      int ce, e0, e1, d, sh;
      logic [MW-1:0] m, st;
      logic [63:0] recon, errBox, errCom;
      makeSample(i, ce, e0, e1);
      m = {1'b1, MW'($urandom)}; m[MW-1] = 1'b1;
      @(negedge clk);
      encCommonExp = EW'(ce); encExp[0] = EW'(e0); encExp[1] = EW'(e1);
      encMant[0] = m; encMant[1] = m; encInValid = 1'b1;
      @(negedge clk);
      encInValid = 1'b0;
      #1;
      st = encOutMant[0];
      decCommonExp = encOutCommonExp; decBox = encOutBox; decMant = encOutMant;
      decSign = encOutSign; decInValid = 1'b1;
      @(negedge clk);
      decInValid = 1'b0;
      #1;
      d = (e0 > ce) ? 0 : ce - e0;
      sh = int'($signed(decOutExp[0])) - e0;
      recon = (st == '0 || sh < 0 || sh >= 48) ? 64'd0 : 64'(st) << sh;
      errBox = 64'(m) - recon;
      errCom = (d >= MW) ? 64'(m) : 64'(m) - ((64'(m) >> d) << d);
      check(errBox <= errCom, "R9 round-trip error bound", errBox, errCom);
      if (d < K + MW)
        check(st != '0, "R9 lead kept in box range", st, 1);
    end
    finish();
  end
endmodule